// File: doc/BRIEF.md
# Sorted Price-Priority Order Table

This block holds the resting orders for one side of an order book in a fixed-depth table. The table is always sorted by price, so the best order is always in slot 0 and can be read straight from the head outputs. Each slot holds a 20-bit price, a 16-bit quantity and an 8-bit order identifier. A parameter sets the side. On the buy side the highest price leads. On the sell side the lowest price leads.

Each command does exactly one thing: insert an order, pop the head, cancel an order by its identifier, or take a fill against the head. The block never re-sorts the table. Per-slot comparators produce one result per slot. A first-set priority encoder turns those results into a single slot index. Every slot then loads from itself, from its upper neighbour, from its lower neighbour, or from the incoming order. The new state is therefore ready one clock after the command at any depth. Prices are packed BCD with five digits, and the block compares them as plain unsigned binary numbers.

Top module: `price_table`

## Requirements
- R1: After reset the table is empty: `empty`=1, `full`=0, `count`=0, `head_valid`=0.
- R2: With `ASK_SIDE`=0, the head is always the entry with the highest price.
- R3: With `ASK_SIDE`=1, the head is always the entry with the lowest price.
- R4: A new entry whose price equals one or more stored prices goes after all of them, so the older order keeps priority.
- R5: An insert (`cmd_op`=2'd1) while `full`=1 raises `reject` for one cycle. The table and `count` stay unchanged.
- R6: A pop (`cmd_op`=2'd2) removes the head, moves every other entry one slot toward the head, and lowers `count` by one. A pop on an empty table has no effect.
- R7: A cancel (`cmd_op`=2'd3) removes the entry nearest the head whose identifier equals `cmd_oid`. Later entries move up to close the gap, and `count` drops by one.
- R8: A cancel whose identifier matches no valid entry raises `not_found` for one cycle and leaves the table unchanged.
- R9: A fill (`cmd_op`=2'd0) lowers the head quantity by `cmd_qty`. If `cmd_qty` is greater than or equal to the head quantity, the head is removed as in a pop. A fill on an empty table has no effect.
- R10: Prices are compared as unsigned binary values of their packed BCD code. For example, 20'h00100 (one hundred) ranks above 20'h00099 on the buy side.
- R11: The result of every command appears on the head outputs, `count`, `full` and `empty` right after the next rising clock edge. `full` is 1 exactly when `count` equals `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 0 fill, 1 insert, 2 pop, 3 cancel |
| cmd_price | input | 20 | Price of the inserted order (packed BCD) |
| cmd_qty | input | 16 | Quantity to insert, or amount to fill |
| cmd_oid | input | 8 | Identifier to insert or to cancel |
| head_valid | output | 1 | Slot 0 holds an order |
| head_price | output | 20 | Price of the head order |
| head_qty | output | 16 | Remaining quantity of the head order |
| head_oid | output | 8 | Identifier of the head order |
| full | output | 1 | All slots are occupied |
| empty | output | 1 | No slot is occupied |
| count | output | $clog2(DEPTH+1) | Number of stored orders |
| reject | output | 1 | One-cycle pulse: an insert was refused because the table was full |
| not_found | output | 1 | One-cycle pulse: a cancel matched no order |

## Verification
The bench inserts an order at a price already in the table. A design that broke ties the wrong way would put the newer order at the head after the older one is filled. It inserts into a full table and cancels an identifier that is not present. A design that shifted anyway would change `count` or the head. It fills with exactly the head quantity and with more than the head quantity. A design that only subtracted would leave a zero-quantity head behind or wrap the quantity around. It places 100 and 99 in BCD on both sides, and it cancels an order in the middle and then pops. A design that closed the gap wrongly would show a stale or duplicated order at the head.

// File: rtl/ob_pkg.sv
package ob_pkg;
  localparam int PRICE_W = 20;
  localparam int QTY_W   = 16;
  localparam int OID_W   = 8;

  typedef enum logic [1:0] {
    OP_FILL   = 2'd0,
    OP_INS    = 2'd1,
    OP_POP    = 2'd2,
    OP_CANCEL = 2'd3
  } op_e;

  typedef struct packed {
    logic [PRICE_W-1:0] price;
    logic [QTY_W-1:0]   qty;
    logic [OID_W-1:0]   oid;
  } slot_t;

  // Strictly better price for the given side; packed BCD ranks as plain binary.
  function automatic logic ranks_above(input logic [PRICE_W-1:0] a,
                                       input logic [PRICE_W-1:0] b,
                                       input logic ask_side);
    return ask_side ? (a < b) : (a > b);
  endfunction
endpackage

// File: rtl/ob_slot_cmp.sv
module ob_slot_cmp
  import ob_pkg::*;
#(
  parameter bit ASK_SIDE = 1'b0
) (
  input  slot_t              slot,
  input  logic               slot_vld,
  input  logic [PRICE_W-1:0] key_price,
  input  logic [OID_W-1:0]   key_oid,
  output logic               goes_here,
  output logic               id_hit
);
  // A new order lands at or before this slot if the slot is free or ranks below it.
  assign goes_here = !slot_vld || ranks_above(key_price, slot.price, ASK_SIDE);
  assign id_hit    = slot_vld && (slot.oid == key_oid);
endmodule

// File: rtl/ob_first_set.sv
module ob_first_set #(
  parameter int N  = 32,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic [AW-1:0] idx,
  output logic          found
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = AW'(i);
    end
  end
  assign found = |vec;
endmodule

// File: rtl/price_table.sv
module price_table
  import ob_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter bit ASK_SIDE = 1'b0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [PRICE_W-1:0] cmd_price,
  input  logic [QTY_W-1:0]   cmd_qty,
  input  logic [OID_W-1:0]   cmd_oid,
  output logic               head_valid,
  output logic [PRICE_W-1:0] head_price,
  output logic [QTY_W-1:0]   head_qty,
  output logic [OID_W-1:0]   head_oid,
  output logic               full,
  output logic               empty,
  output logic [CW-1:0]      count,
  output logic               reject,
  output logic               not_found
);
  slot_t              tbl_q   [DEPTH];
  slot_t              tbl_d   [DEPTH];
  slot_t              from_up [DEPTH];
  slot_t              from_dn [DEPTH];
  logic [DEPTH-1:0]   vld_q, vld_d, vld_up, vld_dn;
  logic [DEPTH-1:0]   place_vec, hit_vec;
  logic [AW-1:0]      ins_pos, hit_pos, rm_pos;
  logic               ins_found, hit_found;
  logic [CW-1:0]      cnt_q;
  logic               rej_q, nf_q;

  // Named command events, shared with the assertions
  logic ev_ins, ev_rej, ev_pop, ev_cancel, ev_miss, ev_fill_part, ev_fill_kill, ev_rm;
  slot_t new_slot;

  assign new_slot = '{price: cmd_price, qty: cmd_qty, oid: cmd_oid};

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    ob_slot_cmp #(.ASK_SIDE(ASK_SIDE)) u_cmp (
      .slot     (tbl_q[i]),
      .slot_vld (vld_q[i]),
      .key_price(cmd_price),
      .key_oid  (cmd_oid),
      .goes_here(place_vec[i]),
      .id_hit   (hit_vec[i])
    );
  end

  ob_first_set #(.N(DEPTH)) u_ins_pe (.vec(place_vec), .idx(ins_pos), .found(ins_found));
  ob_first_set #(.N(DEPTH)) u_hit_pe (.vec(hit_vec),   .idx(hit_pos), .found(hit_found));

  always_comb begin
    ev_ins       = cmd_valid && (cmd_op == OP_INS) && !full && ins_found;
    ev_rej       = cmd_valid && (cmd_op == OP_INS) && full;
    ev_pop       = cmd_valid && (cmd_op == OP_POP) && vld_q[0];
    ev_cancel    = cmd_valid && (cmd_op == OP_CANCEL) && hit_found;
    ev_miss      = cmd_valid && (cmd_op == OP_CANCEL) && !hit_found;
    ev_fill_kill = cmd_valid && (cmd_op == OP_FILL) && vld_q[0] && (cmd_qty >= tbl_q[0].qty);
    ev_fill_part = cmd_valid && (cmd_op == OP_FILL) && vld_q[0] && (cmd_qty <  tbl_q[0].qty);
    ev_rm        = ev_pop || ev_cancel || ev_fill_kill;
    rm_pos       = ev_cancel ? hit_pos : '0;
  end

  // Neighbour views for the one-place shift in either direction
  for (genvar i = 0; i < DEPTH; i++) begin : g_nbr
    if (i == DEPTH - 1) begin : g_last
      assign from_up[i] = '0;
      assign vld_up[i]  = 1'b0;
    end else begin : g_mid
      assign from_up[i] = tbl_q[i+1];
      assign vld_up[i]  = vld_q[i+1];
    end
    if (i == 0) begin : g_first
      assign from_dn[i] = '0;
      assign vld_dn[i]  = 1'b0;
    end else begin : g_rest
      assign from_dn[i] = tbl_q[i-1];
      assign vld_dn[i]  = vld_q[i-1];
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_next
    always_comb begin
      tbl_d[i] = tbl_q[i];
      vld_d[i] = vld_q[i];
      if (ev_ins) begin
        if (AW'(i) == ins_pos) begin
          tbl_d[i] = new_slot;
          vld_d[i] = 1'b1;
        end else if (AW'(i) > ins_pos) begin
          tbl_d[i] = from_dn[i];
          vld_d[i] = vld_dn[i];
        end
      end else if (ev_rm) begin
        if (AW'(i) >= rm_pos) begin
          tbl_d[i] = from_up[i];
          vld_d[i] = vld_up[i];
        end
      end else if (ev_fill_part && (i == 0)) begin
        tbl_d[i].qty = tbl_q[i].qty - cmd_qty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= '0;
      vld_q <= '0;
      cnt_q <= '0;
      rej_q <= 1'b0;
      nf_q  <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= tbl_d[i];
      vld_q <= vld_d;
      if (ev_ins)     cnt_q <= cnt_q + 1'b1;
      else if (ev_rm) cnt_q <= cnt_q - 1'b1;
      rej_q <= ev_rej;
      nf_q  <= ev_miss;
    end
  end

  assign head_valid = vld_q[0];
  assign head_price = tbl_q[0].price;
  assign head_qty   = tbl_q[0].qty;
  assign head_oid   = tbl_q[0].oid;
  assign count      = cnt_q;
  assign full       = (cnt_q == CW'(DEPTH));
  assign empty      = (cnt_q == '0);
  assign reject     = rej_q;
  assign not_found  = nf_q;

  for (genvar i = 0; i + 1 < DEPTH; i++) begin : g_order_chk
    // R2 R3 R4
    sorted_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q[i+1] |-> (vld_q[i] && !ranks_above(tbl_q[i+1].price, tbl_q[i].price, ASK_SIDE)));
  end

  // R5
  full_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_INS && full) |=> (reject && $stable(count)));

  // R11
  insert_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_INS && !full) |=> (count == $past(count) + 1'b1));

  // R8
  miss_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    not_found |-> (count == $past(count) && head_oid == $past(head_oid)));

  // R9
  fill_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_part |=> (head_qty == $past(head_qty) - $past(cmd_qty) && $stable(count)));

  // R6
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_POP && empty) |=> empty);
endmodule

// File: tb/sim_price_table.sv
`timescale 1ns/1ps
module sim_price_table;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  localparam int D = 4;
  localparam int CW = $clog2(D + 1);

  // Bid-side instance
  logic a_v; logic [1:0] a_op; logic [19:0] a_pr; logic [15:0] a_q; logic [7:0] a_id;
  logic a_hv, a_full, a_empty, a_rej, a_nf;
  logic [19:0] a_hp; logic [15:0] a_hq; logic [7:0] a_ho; logic [CW-1:0] a_cnt;
  // Ask-side instance
  logic b_v; logic [1:0] b_op; logic [19:0] b_pr; logic [15:0] b_q; logic [7:0] b_id;
  logic b_hv, b_full, b_empty, b_rej, b_nf;
  logic [19:0] b_hp; logic [15:0] b_hq; logic [7:0] b_ho; logic [CW-1:0] b_cnt;

  price_table #(.DEPTH(D), .ASK_SIDE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(a_v), .cmd_op(a_op), .cmd_price(a_pr),
    .cmd_qty(a_q), .cmd_oid(a_id), .head_valid(a_hv), .head_price(a_hp),
    .head_qty(a_hq), .head_oid(a_ho), .full(a_full), .empty(a_empty),
    .count(a_cnt), .reject(a_rej), .not_found(a_nf));

  price_table #(.DEPTH(D), .ASK_SIDE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(b_v), .cmd_op(b_op), .cmd_price(b_pr),
    .cmd_qty(b_q), .cmd_oid(b_id), .head_valid(b_hv), .head_price(b_hp),
    .head_qty(b_hq), .head_oid(b_ho), .full(b_full), .empty(b_empty),
    .count(b_cnt), .reject(b_rej), .not_found(b_nf));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Vector: op(2) price(20) qty(16) oid(8) | exp valid(1) price(20) qty(16) oid(8) count(3) reject(1) miss(1)
  localparam int NV = 12;
  localparam logic [95:0] VEC [NV] = '{
    {2'd1, 20'h00500, 16'd10, 8'd1, 1'b1, 20'h00500, 16'd10, 8'd1, 3'd1, 1'b0, 1'b0}, // R2
    {2'd1, 20'h00700, 16'd20, 8'd2, 1'b1, 20'h00700, 16'd20, 8'd2, 3'd2, 1'b0, 1'b0}, // R2
    {2'd1, 20'h00600, 16'd5,  8'd3, 1'b1, 20'h00700, 16'd20, 8'd2, 3'd3, 1'b0, 1'b0}, // R11
    {2'd1, 20'h00700, 16'd7,  8'd4, 1'b1, 20'h00700, 16'd20, 8'd2, 3'd4, 1'b0, 1'b0}, // R4
    {2'd1, 20'h00900, 16'd1,  8'd5, 1'b1, 20'h00700, 16'd20, 8'd2, 3'd4, 1'b1, 1'b0}, // R5
    {2'd0, 20'h00000, 16'd5,  8'd0, 1'b1, 20'h00700, 16'd15, 8'd2, 3'd4, 1'b0, 1'b0}, // R9
    {2'd0, 20'h00000, 16'd15, 8'd0, 1'b1, 20'h00700, 16'd7,  8'd4, 3'd3, 1'b0, 1'b0}, // R9
    {2'd3, 20'h00000, 16'd0,  8'd3, 1'b1, 20'h00700, 16'd7,  8'd4, 3'd2, 1'b0, 1'b0}, // R7
    {2'd3, 20'h00000, 16'd0,  8'd9, 1'b1, 20'h00700, 16'd7,  8'd4, 3'd2, 1'b0, 1'b1}, // R8
    {2'd2, 20'h00000, 16'd0,  8'd0, 1'b1, 20'h00500, 16'd10, 8'd1, 3'd1, 1'b0, 1'b0}, // R6
    {2'd2, 20'h00000, 16'd0,  8'd0, 1'b0, 20'h00000, 16'd0,  8'd0, 3'd0, 1'b0, 1'b0}, // R6
    {2'd2, 20'h00000, 16'd0,  8'd0, 1'b0, 20'h00000, 16'd0,  8'd0, 3'd0, 1'b0, 1'b0}  // R6
  };

  function automatic string vec_tag(input int k);
    case (k)
      0, 1:    return "R2";
      2:       return "R11";
      3:       return "R4";
      4:       return "R5";
      5, 6:    return "R9";
      7:       return "R7";
      8:       return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Drive one command on the selected side; return just after the capturing edge.
  task automatic issue(input bit ask, input logic [1:0] op, input logic [19:0] pr,
                       input logic [15:0] q, input logic [7:0] id);
    @(negedge clk);
    if (ask) begin b_v = 1'b1; b_op = op; b_pr = pr; b_q = q; b_id = id; end
    else     begin a_v = 1'b1; a_op = op; a_pr = pr; a_q = q; a_id = id; end
    @(posedge clk);
    #1;
    a_v = 1'b0;
    b_v = 1'b0;
  endtask

  initial begin
    a_v = 0; a_op = 0; a_pr = 0; a_q = 0; a_id = 0;
    b_v = 0; b_op = 0; b_pr = 0; b_q = 0; b_id = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check("R1", "bid empty", 32'(a_empty), 32'd1);
    check("R1", "bid count", 32'(a_cnt), 32'd0);
    check("R1", "bid head_valid", 32'(a_hv), 32'd0);
    check("R1", "bid full", 32'(a_full), 32'd0);
    check("R1", "ask empty", 32'(b_empty), 32'd1);

    // Vector walk on the bid side
    for (int k = 0; k < NV; k++) begin
      logic [95:0] v;
      v = VEC[k];
      issue(1'b0, v[95:94], v[93:74], v[73:58], v[57:50]);
      check(vec_tag(k), "head_valid", 32'(a_hv), 32'(v[49]));
      if (v[49]) begin
        check(vec_tag(k), "head_price", 32'(a_hp), 32'(v[48:29]));
        check(vec_tag(k), "head_qty", 32'(a_hq), 32'(v[28:13]));
        check(vec_tag(k), "head_oid", 32'(a_ho), 32'(v[12:5]));
      end
      check(vec_tag(k), "count", 32'(a_cnt), 32'(v[4:2]));
      check(vec_tag(k), "reject", 32'(a_rej), 32'(v[1]));
      check(vec_tag(k), "not_found", 32'(a_nf), 32'(v[0]));
    end

    // R10 BCD magnitude on the bid side: 100 ranks above 99
    issue(1'b0, 2'd1, 20'h00099, 16'd4, 8'd20);
    issue(1'b0, 2'd1, 20'h00100, 16'd3, 8'd21);
    check("R10", "bid head price", 32'(a_hp), 32'h00100);
    // R9 overfill removes head
    issue(1'b0, 2'd0, 20'h0, 16'd50, 8'd0);
    check("R9", "overfill head", 32'(a_ho), 32'd20);
    check("R9", "overfill count", 32'(a_cnt), 32'd1);
    // R9 fill on empty has no effect
    issue(1'b0, 2'd2, 20'h0, 16'd0, 8'd0);
    issue(1'b0, 2'd0, 20'h0, 16'd5, 8'd0);
    check("R9", "fill on empty", 32'(a_empty), 32'd1);

    // R3 ask polarity
    issue(1'b1, 2'd1, 20'h00099, 16'd1, 8'd1);
    issue(1'b1, 2'd1, 20'h00100, 16'd2, 8'd2);
    issue(1'b1, 2'd1, 20'h00050, 16'd3, 8'd3);
    check("R3", "ask head lowest", 32'(b_hp), 32'h00050);
    issue(1'b1, 2'd2, 20'h0, 16'd0, 8'd0);
    check("R10", "ask head after pop", 32'(b_hp), 32'h00099);
    issue(1'b1, 2'd1, 20'h00200, 16'd4, 8'd4);
    issue(1'b1, 2'd1, 20'h00300, 16'd5, 8'd5);
    check("R11", "ask full flag", 32'(b_full), 32'd1);
    check("R11", "ask count", 32'(b_cnt), 32'd4);
    // R7 cancel middle entry, then walk the order out
    issue(1'b1, 2'd3, 20'h0, 16'd0, 8'd2);
    check("R7", "ask head after cancel", 32'(b_ho), 32'd1);
    check("R11", "ask full cleared", 32'(b_full), 32'd0);
    issue(1'b1, 2'd2, 20'h0, 16'd0, 8'd0);
    check("R7", "gap closed next", 32'(b_hp), 32'h00200);
    issue(1'b1, 2'd2, 20'h0, 16'd0, 8'd0);
    check("R7", "gap closed last", 32'(b_hp), 32'h00300);
    check("R6", "ask count", 32'(b_cnt), 32'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule